// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter with Auto-Masking

This block sits on the processor side of an interrupt system and chooses which of fourteen maskable request lines is offered to the core. Each line has a pending flag and an enable bit, and one global mask bit gates every line. In every cycle the arbiter looks only at lines that are both pending and enabled, and it picks the one with the lowest line number. When the global mask is clear and the core signals that it is ready, the arbiter raises a take request together with the index of the chosen line.

When the core accepts the take, the arbiter sets the global mask and clears the enable bit of the taken line in the same clock edge. It does not record which level is in service. Once software clears the global mask again, any pending and enabled line can nest on top of the running handler, whether its priority is higher or lower. Write ports let software change the enable register and the global mask. A restore port reloads both in one cycle when a handler returns.

Top module: `irq_arbiter`

## Requirements
- R1: After reset every pending flag is clear, every enable bit is clear, the global mask is 1 and `take_vld` is 0. A request pulse that arrives after reset is not offered until its line is enabled.
- R2: A one-cycle pulse on `irq_req[i]` sets pending flag i at that clock edge. `take_vld` is 1 from the next cycle on when line i is enabled, the global mask is 0 and `cpu_rdy` is 1.
- R3: When several lines are pending and enabled, `take_idx` gives the lowest-numbered one. `take_idx` is the line's bit position in `irq_req`, from 0 to 13.
- R4: `take_vld` is 0 whenever the global mask is 1 or `cpu_rdy` is 0.
- R5: A cycle in which `cpu_acc` and `take_vld` are both 1 is an acceptance. The global mask is 1 in the next cycle, so `take_vld` drops.
- R6: An acceptance clears the enable bit of the taken line. A later pulse on that line is not offered after the global mask is cleared, until software sets that enable bit again.
- R7: No in-service level is kept. After an acceptance and a clear of the global mask, a line of higher or of lower priority than the taken one can be taken.
- R8: An acceptance clears the taken line's pending flag. If a new pulse on the same line arrives in the acceptance cycle, the flag stays set.
- R9: `sw_en_we` loads `sw_en_wdata` into the enable register, and `sw_gm_we` loads `sw_gm_wdata` into the global mask. In the same cycle, the clear made by an acceptance wins over the software write on the taken bit and on the global mask.
- R10: `rs_ld` loads `rs_en` into the enable register and `rs_gm` into the global mask in one cycle. Restore takes precedence over a software write in the same cycle, and an acceptance still wins over both.
- R11: If software never re-enables a taken line, at most 14 acceptances can happen before no line can be offered. If software re-enables the taken line each time, the number of nested acceptances has no limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 14 | One-cycle request pulses, one per line |
| cpu_rdy | input | 1 | Core can take an interrupt |
| cpu_acc | input | 1 | Core accepts the offered line |
| sw_en_we | input | 1 | Software write strobe for the enable register |
| sw_en_wdata | input | 14 | Enable value to write |
| sw_gm_we | input | 1 | Software write strobe for the global mask |
| sw_gm_wdata | input | 1 | Global mask value to write |
| rs_ld | input | 1 | Restore strobe for return from service |
| rs_en | input | 14 | Saved enable value |
| rs_gm | input | 1 | Saved global mask value |
| take_vld | output | 1 | A line is offered to the core |
| take_idx | output | 4 | Bit position of the offered line |

## Verification
A wrong enable or pending bit shows at the ports one cycle after the edge that stored it. It appears either as a line offered when it should be blocked, or as `take_vld` staying low. A global mask left clear after an acceptance shows the very next cycle as `take_vld` staying high. A wrong priority choice appears on `take_idx` as soon as two candidates overlap. The bench reaches each of these states through request, accept, write and restore sequences, and then checks the offer in the following cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int IRQ_LINES = 14;
  localparam int IRQ_IDX_W = $clog2(IRQ_LINES);
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int NUM_LINES = irq_pkg::IRQ_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] req,
  input  logic [NUM_LINES-1:0] clr_mask,
  output logic [NUM_LINES-1:0] pend_q
);
  logic [NUM_LINES-1:0] pend_d;

  always_comb pend_d = (pend_q & ~clr_mask) | req;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_d;
  end

  AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (rst)
    (|req) |=> ((pend_q & $past(req)) == $past(req))); // R2
  AST_ACC_CLEARS_PEND: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((pend_q & $past(clr_mask & ~req)) == '0)); // R8
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NUM_LINES = irq_pkg::IRQ_LINES,
  parameter int IDX_W     = irq_pkg::IRQ_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] cand,
  output logic [NUM_LINES-1:0] grant,
  output logic [IDX_W-1:0]     idx
);
  logic [NUM_LINES:0] below_any;

  assign below_any[0] = 1'b0;
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_prio
    assign grant[i]       = cand[i] & ~below_any[i];
    assign below_any[i+1] = below_any[i] | cand[i];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (grant[i]) idx = IDX_W'(i);
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((|cand) == (|grant))); // R3
endmodule

// File: rtl/irq_mask_state.sv
module irq_mask_state #(
  parameter int NUM_LINES = irq_pkg::IRQ_LINES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fire,
  input  logic [NUM_LINES-1:0] clr_mask,
  input  logic                 sw_en_we,
  input  logic [NUM_LINES-1:0] sw_en_wdata,
  input  logic                 sw_gm_we,
  input  logic                 sw_gm_wdata,
  input  logic                 rs_ld,
  input  logic [NUM_LINES-1:0] rs_en,
  input  logic                 rs_gm,
  output logic [NUM_LINES-1:0] en_q,
  output logic                 gm_q
);
  logic [NUM_LINES-1:0] en_sel;
  logic                 gm_sel;

  always_comb begin
    en_sel = en_q;
    gm_sel = gm_q;
    if (rs_ld) begin
      en_sel = rs_en;
      gm_sel = rs_gm;
    end else begin
      if (sw_en_we) en_sel = sw_en_wdata;
      if (sw_gm_we) gm_sel = sw_gm_wdata;
    end
    if (fire) gm_sel = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      gm_q <= 1'b1;
    end else begin
      en_q <= en_sel & ~clr_mask;
      gm_q <= gm_sel;
    end
  end

  AST_ACC_SETS_GM: assert property (@(posedge clk) disable iff (rst)
    fire |=> gm_q); // R5
  AST_ACC_CLEARS_EN: assert property (@(posedge clk) disable iff (rst)
    (|clr_mask) |=> ((en_q & $past(clr_mask)) == '0)); // R6
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_LINES = irq_pkg::IRQ_LINES,
  parameter int IDX_W     = irq_pkg::IRQ_IDX_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_req,
  input  logic                 cpu_rdy,
  input  logic                 cpu_acc,
  input  logic                 sw_en_we,
  input  logic [NUM_LINES-1:0] sw_en_wdata,
  input  logic                 sw_gm_we,
  input  logic                 sw_gm_wdata,
  input  logic                 rs_ld,
  input  logic [NUM_LINES-1:0] rs_en,
  input  logic                 rs_gm,
  output logic                 take_vld,
  output logic [IDX_W-1:0]     take_idx
);
  logic [NUM_LINES-1:0] pend_q;
  logic [NUM_LINES-1:0] en_q;
  logic                 gm_q;
  logic [NUM_LINES-1:0] cand;
  logic [NUM_LINES-1:0] grant;
  logic [NUM_LINES-1:0] clr_mask;
  logic                 fire;

  assign cand     = pend_q & en_q;
  assign take_vld = cpu_rdy & ~gm_q & (|cand);
  assign fire     = cpu_acc & take_vld;
  assign clr_mask = grant & {NUM_LINES{fire}};

  irq_pending #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .req(irq_req), .clr_mask(clr_mask), .pend_q(pend_q)
  );

  irq_select #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .cand(cand), .grant(grant), .idx(take_idx)
  );

  irq_mask_state #(.NUM_LINES(NUM_LINES)) u_mask (
    .clk(clk), .rst(rst), .fire(fire), .clr_mask(clr_mask),
    .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
    .sw_gm_we(sw_gm_we), .sw_gm_wdata(sw_gm_wdata),
    .rs_ld(rs_ld), .rs_en(rs_en), .rs_gm(rs_gm),
    .en_q(en_q), .gm_q(gm_q)
  );

  AST_GM_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (rst)
    gm_q |-> !take_vld); // R4
  AST_OFFER_IS_LIVE: assert property (@(posedge clk) disable iff (rst)
    take_vld |-> (pend_q[take_idx] && en_q[take_idx])); // R3
endmodule

// File: tb/irq_arbiter_tb.sv
module irq_arbiter_tb;
  localparam int N = 14;
  localparam logic [N-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq_req = '0;
  logic cpu_rdy = 1'b1, cpu_acc = 1'b0;
  logic sw_en_we = 1'b0, sw_gm_we = 1'b0, sw_gm_wdata = 1'b0;
  logic [N-1:0] sw_en_wdata = '0;
  logic rs_ld = 1'b0, rs_gm = 1'b0;
  logic [N-1:0] rs_en = '0;
  logic take_vld;
  logic [3:0] take_idx;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_arbiter u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .cpu_rdy(cpu_rdy), .cpu_acc(cpu_acc),
    .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata), .sw_gm_we(sw_gm_we),
    .sw_gm_wdata(sw_gm_wdata), .rs_ld(rs_ld), .rs_en(rs_en), .rs_gm(rs_gm),
    .take_vld(take_vld), .take_idx(take_idx)
  );

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_offer(input string tag, input int vld, input int idx);
    chk({tag, " vld"}, int'(take_vld), vld);
    if (vld == 1) chk({tag, " idx"}, int'(take_idx), idx);
  endtask

  task automatic do_reset();
    rst = 1'b1; cpu_rdy = 1'b1; step(); step(); rst = 1'b0;
  endtask

  task automatic pulse(input logic [N-1:0] m);
    irq_req = m; step(); irq_req = '0;
  endtask

  task automatic wr_en(input logic [N-1:0] m);
    sw_en_we = 1'b1; sw_en_wdata = m; step(); sw_en_we = 1'b0;
  endtask

  task automatic wr_gm(input logic v);
    sw_gm_we = 1'b1; sw_gm_wdata = v; step(); sw_gm_we = 1'b0;
  endtask

  task automatic accept();
    cpu_acc = 1'b1; step(); cpu_acc = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk_offer("R1 after reset", 0, 0);
    pulse(ALL);
    wr_gm(1'b0);
    chk_offer("R1 enables clear at reset", 0, 0);
    wr_en(ALL);
    chk_offer("R1 offered after enable", 1, 0);
  endtask

  task automatic t_basic();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    chk_offer("R2 idle", 0, 0);
    pulse(14'd1 << 6);
    chk_offer("R2 single line", 1, 6);
  endtask

  task automatic t_priority();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse((14'd1 << 4) | (14'd1 << 9) | (14'd1 << 11));
    chk_offer("R3 lowest wins", 1, 4);
    accept();
    chk_offer("R5 mask set after accept", 0, 0);
    wr_gm(1'b0);
    chk_offer("R3 next candidate", 1, 9);
  endtask

  task automatic t_block();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse(14'd1 << 3);
    cpu_rdy = 1'b0; #1;
    chk_offer("R4 core not ready", 0, 0);
    cpu_rdy = 1'b1; #1;
    wr_gm(1'b1);
    chk_offer("R4 global mask set", 0, 0);
    cpu_acc = 1'b1; step(); cpu_acc = 1'b0;
    wr_gm(1'b0);
    chk_offer("R4 accept ignored while masked", 1, 3);
  endtask

  task automatic t_self_mask();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse(14'd1 << 2);
    accept(); wr_gm(1'b0);
    pulse(14'd1 << 2);
    chk_offer("R6 taken line blocked", 0, 0);
    wr_en(ALL);
    chk_offer("R6 re-enabled line offered", 1, 2);
  endtask

  task automatic t_nest();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse(14'd1 << 5);
    accept(); wr_gm(1'b0);
    pulse(14'd1 << 9);
    chk_offer("R7 lower priority nests", 1, 9);
    accept(); wr_gm(1'b0);
    pulse(14'd1 << 1);
    chk_offer("R7 higher priority nests", 1, 1);
  endtask

  task automatic t_pend();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse(14'd1 << 7);
    accept(); wr_en(ALL); wr_gm(1'b0);
    chk_offer("R8 pending cleared by accept", 0, 0);
    pulse(14'd1 << 7);
    cpu_acc = 1'b1; irq_req = 14'd1 << 7; step(); cpu_acc = 1'b0; irq_req = '0;
    wr_en(ALL); wr_gm(1'b0);
    chk_offer("R8 same-cycle pulse keeps pending", 1, 7);
  endtask

  task automatic t_sw_conflict();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    pulse((14'd1 << 3) | (14'd1 << 8));
    cpu_acc = 1'b1; sw_en_we = 1'b1; sw_en_wdata = ALL;
    sw_gm_we = 1'b1; sw_gm_wdata = 1'b0;
    step();
    cpu_acc = 1'b0; sw_en_we = 1'b0; sw_gm_we = 1'b0;
    chk_offer("R9 accept beats sw mask write", 0, 0);
    wr_gm(1'b0);
    chk_offer("R9 other bits written", 1, 8);
    accept(); wr_gm(1'b0);
    pulse(14'd1 << 3);
    chk_offer("R9 accept beats sw enable write", 0, 0);
  endtask

  task automatic t_restore();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    rs_ld = 1'b1; rs_en = 14'd1 << 10; rs_gm = 1'b0;
    sw_en_we = 1'b1; sw_en_wdata = ALL; step();
    rs_ld = 1'b0; sw_en_we = 1'b0;
    pulse((14'd1 << 2) | (14'd1 << 10));
    chk_offer("R10 restore enable beats sw", 1, 10);
    rs_ld = 1'b1; rs_en = ALL; rs_gm = 1'b1; step(); rs_ld = 1'b0;
    chk_offer("R10 restore sets mask", 0, 0);
    rs_ld = 1'b1; rs_gm = 1'b0; step(); rs_ld = 1'b0;
    chk_offer("R10 restore clears mask", 1, 2);
  endtask

  task automatic t_depth();
    do_reset(); wr_en(ALL); wr_gm(1'b0);
    for (int k = 0; k < N; k++) begin
      pulse(ALL);
      chk_offer("R11 bounded nesting", 1, k);
      accept(); wr_gm(1'b0);
    end
    pulse(ALL);
    chk_offer("R11 all enables exhausted", 0, 0);
    do_reset(); wr_en(14'd1); wr_gm(1'b0);
    for (int k = 0; k < 20; k++) begin
      pulse(14'd1);
      chk_offer("R11 unbounded nesting", 1, 0);
      accept();
      sw_en_we = 1'b1; sw_en_wdata = 14'd1; sw_gm_we = 1'b1; sw_gm_wdata = 1'b0;
      step();
      sw_en_we = 1'b0; sw_gm_we = 1'b0;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    t_reset();
    t_basic();
    t_priority();
    t_block();
    t_self_mask();
    t_nest();
    t_pend();
    t_sw_conflict();
    t_restore();
    t_depth();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule